// File: doc/BRIEF.md
# Duty-Cycle Code Interpolator

This block converts a fine 18-bit output code into a stream of 16-bit codes for a coarse converter. It splits the fine code into a 16-bit base value and a 2-bit fraction. It then alternates the coarse code between the base and the base plus one, so that the average over time lands on the fine code.

The interpolation period has four equal phases. An internal divider sets the length of each phase in system clock cycles. With the default divide ratio and a 100 MHz clock, the full four-phase sequence repeats at 10 kHz.

A new fine code is presented with a one-cycle load strobe. It becomes active only at the boundary between two periods, so a period in progress always finishes with a single code. The analog smoothing after the coarse converter is outside this block.

Top module: `code_interp`

## Requirements
- R1: The base value is bits 17..2 of the active code. In every phase that is not a high phase, the output equals the base value.
- R2: The fraction is bits 1..0 of the active code. Fractions 0, 1, 2 and 3 give 0, 1, 2 and 3 high phases out of four. The high phases come first in the period (phase index below the fraction), and a high phase outputs base + 1.
- R3: Each phase lasts exactly PHASE_DIV clock cycles, and the output is constant within a phase. A period is 4 × PHASE_DIV cycles. The default of 2500 gives a 10 kHz period at 100 MHz.
- R4: When the base is below 0xFFFF, the sum of the four phase outputs of one period equals the 18-bit active code.
- R5: When the base is 0xFFFF, a high phase outputs 0xFFFF instead of wrapping, so the output stays at 0xFFFF for the whole period.
- R6: A load during a period does not change that period's output. Code input changes without a strobe have no effect. The loaded code becomes active at the next period boundary.
- R7: A strobe on the last cycle of a period, which shares its clock edge with the period boundary, makes that code active for the very next period.
- R8: If several strobes occur within one period, the code of the last strobe is the one that becomes active.
- R9: While reset is high, the output is 0. After reset, the active code is 0 and phase 0 starts on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| loadStrobe | input | 1 | One-cycle strobe that captures codeIn |
| codeIn | input | CODE_W (18) | Fine output code |
| coarseOut | output | CODE_W-2 (16) | Code driven to the coarse converter |

## Verification
The bench builds the block with PHASE_DIV = 5, so one period is 20 cycles. With periods this short, every cycle of every period can be compared against an expected phase pattern, and a dozen periods cover all four fractions, the saturated full-scale codes and the three load timings. The bench takes loads mid-period, on the shared boundary edge and twice in one period. Between strobes it drives noise on the code input. This exercises the divider, the phase order and the boundary capture at a scale where each phase edge is visible.

// File: rtl/interp_pkg.sv
package interp_pkg;
  // Width of the fractional part; the period has 2**FRAC_W phases.
  localparam int FRAC_W = 2;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic              phaseTick;  // this edge ends the current phase
    logic              lastPhase;  // current phase is the last of the period
    logic [FRAC_W-1:0] phase;      // current phase index
  } seqCtl_t;
endpackage

// File: rtl/interp_seq.sv
module interp_seq
  import interp_pkg::*;
#(
  parameter int PHASE_DIV = 2500
) (
  input  logic    clk,
  input  logic    rst,
  output seqCtl_t ctl
);
  logic              tick;
  logic [FRAC_W-1:0] phase;

  generate
    if (PHASE_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CNT_W = $clog2(PHASE_DIV);
      localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PHASE_DIV - 1);
      logic [CNT_W-1:0] divCnt;

      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          divCnt <= '0;
        end else if (divCnt == LAST_CNT) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + CNT_W'(1);
        end
      end

      assign tick = (divCnt == LAST_CNT);
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase <= '0;
    end else if (tick) begin
      phase <= phase + FRAC_W'(1);
    end
  end

  always_comb begin
    ctl.phaseTick = tick;
    ctl.lastPhase = (phase == '1);
    ctl.phase     = phase;
  end
endmodule

// File: rtl/interp_path.sv
module interp_path
  import interp_pkg::*;
#(
  parameter int CODE_W = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     loadStrobe,
  input  logic [CODE_W-1:0]        codeIn,
  input  seqCtl_t                  ctl,
  output logic [CODE_W-FRAC_W-1:0] coarseOut,
  output logic [CODE_W-1:0]        activeCode
);
  localparam int COARSE_W = CODE_W - FRAC_W;

  logic [CODE_W-1:0]   pendCode;
  logic                periodWrap;
  logic [COARSE_W-1:0] baseCode;
  logic [COARSE_W-1:0] upperCode;
  logic [FRAC_W-1:0]   fracCode;
  logic                highPhase;

  assign periodWrap = ctl.phaseTick && ctl.lastPhase;

  // Latest loaded code, waiting for the next period boundary.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pendCode <= '0;
    end else if (loadStrobe) begin
      pendCode <= codeIn;
    end
  end

  // Code in force for the running period; a strobe on the wrap edge wins.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      activeCode <= '0;
    end else if (periodWrap) begin
      activeCode <= loadStrobe ? codeIn : pendCode;
    end
  end

  always_comb begin
    baseCode  = activeCode[CODE_W-1:FRAC_W];
    fracCode  = activeCode[FRAC_W-1:0];
    upperCode = (baseCode == '1) ? baseCode : baseCode + COARSE_W'(1);
    highPhase = (ctl.phase < fracCode);
    coarseOut = highPhase ? upperCode : baseCode;
  end
endmodule

// File: rtl/code_interp.sv
module code_interp
  import interp_pkg::*;
#(
  parameter int CODE_W    = 18,
  parameter int PHASE_DIV = 2500
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     loadStrobe,
  input  logic [CODE_W-1:0]        codeIn,
  output logic [CODE_W-FRAC_W-1:0] coarseOut
);
  seqCtl_t           ctl;
  logic [CODE_W-1:0] activeCode;

  interp_seq #(
    .PHASE_DIV(PHASE_DIV)
  ) u_seq (
    .clk(clk),
    .rst(rst),
    .ctl(ctl)
  );

  interp_path #(
    .CODE_W(CODE_W)
  ) u_path (
    .clk(clk),
    .rst(rst),
    .loadStrobe(loadStrobe),
    .codeIn(codeIn),
    .ctl(ctl),
    .coarseOut(coarseOut),
    .activeCode(activeCode)
  );
endmodule

// File: rtl/code_interp_chk.sv
module code_interp_chk
  import interp_pkg::*;
#(
  parameter int CODE_W = 18
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     loadStrobe,
  input logic [CODE_W-1:0]        codeIn,
  input logic [CODE_W-FRAC_W-1:0] coarseOut,
  input seqCtl_t                  ctl,
  input logic [CODE_W-1:0]        activeCode
);
  localparam int COARSE_W = CODE_W - FRAC_W;

  logic [COARSE_W-1:0] chkBase;
  logic [FRAC_W-1:0]   chkFrac;
  assign chkBase = activeCode[CODE_W-1:FRAC_W];
  assign chkFrac = activeCode[FRAC_W-1:0];

  assert_base_only_R1: assert property (@(posedge clk) disable iff (rst)
    (chkFrac == '0) |-> (coarseOut == chkBase));

  assert_adjacent_R2: assert property (@(posedge clk) disable iff (rst)
    (coarseOut == chkBase) || (coarseOut == chkBase + COARSE_W'(1)));

  assert_first_high_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl.phase == '0 && chkFrac != '0 && chkBase != '1) |-> (coarseOut != chkBase));

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.phase != $past(ctl.phase)) |-> $past(ctl.phaseTick));

  assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
    (chkBase == '1) |-> (coarseOut == '1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(ctl.phaseTick && ctl.lastPhase) |-> $stable(activeCode));

  assert_edge_load_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl.phaseTick && ctl.lastPhase && loadStrobe) |=> (activeCode == $past(codeIn)));

  assert_reset_out_R9: assert property (@(posedge clk)
    rst |-> (coarseOut == '0));
endmodule

bind code_interp code_interp_chk #(
  .CODE_W(CODE_W)
) u_chk (
  .clk(clk),
  .rst(rst),
  .loadStrobe(loadStrobe),
  .codeIn(codeIn),
  .coarseOut(coarseOut),
  .ctl(ctl),
  .activeCode(activeCode)
);

// File: tb/sim_code_interp.sv
module sim_code_interp;
  localparam int D   = 5;
  localparam int PER = 4 * D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadStrobe = 1'b0;
  logic [17:0] codeIn = '0;
  logic [15:0] coarseOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct {
    int          per;
    logic [17:0] code;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [17:0] curCode = '0;
  string       curTag  = "R9";
  logic [15:0] samp [PER];
  int          monK;

  always #5 clk = ~clk;

  code_interp #(.CODE_W(18), .PHASE_DIV(D)) u0 (
    .clk(clk), .rst(rst), .loadStrobe(loadStrobe),
    .codeIn(codeIn), .coarseOut(coarseOut)
  );

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkPeriod(input int p);
    exp_t        it;
    logic [15:0] base, up, expv;
    logic [1:0]  fr;
    int          nUp, sum;
    bit          same;
    while (q.size() > 0 && q[0].per < p) begin
      it = q.pop_front();
      check(1'b0, it.tag, "period not observed", p, it.per);
    end
    if (q.size() > 0 && q[0].per == p) begin
      it   = q.pop_front();
      base = it.code[17:2];
      fr   = it.code[1:0];
      up   = (base == 16'hFFFF) ? base : base + 16'd1;
      nUp  = 0;
      sum  = 0;
      for (int ph = 0; ph < 4; ph++) begin
        expv = (ph < int'(fr)) ? up : base;
        if (ph < int'(fr))
          check(samp[ph*D] == expv, (base == 16'hFFFF) ? "R5" : "R2",
                $sformatf("high phase %0d (%s)", ph, it.tag), samp[ph*D], expv);
        else
          check(samp[ph*D] == expv, "R1",
                $sformatf("base phase %0d (%s)", ph, it.tag), samp[ph*D], expv);
        same = 1'b1;
        for (int c = 1; c < D; c++) if (samp[ph*D+c] != samp[ph*D]) same = 1'b0;
        check(same, "R3", $sformatf("phase %0d constant (%s)", ph, it.tag),
              same, 1);
        if (samp[ph*D] != base) nUp++;
        sum += int'(samp[ph*D]);
      end
      check(nUp == ((base == 16'hFFFF) ? 0 : int'(fr)), "R2",
            $sformatf("high phase count (%s)", it.tag), nUp,
            (base == 16'hFFFF) ? 0 : int'(fr));
      if (base != 16'hFFFF)
        check(sum == int'(it.code), "R4", $sformatf("period sum (%s)", it.tag),
              sum, int'(it.code));
    end
  endtask

  // Monitor: gathers one period of samples and compares against the scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      monK = cyc % PER;
      samp[monK] = coarseOut;
      if (monK == PER - 1) checkPeriod(cyc / PER);
    end
  end

  // Driver: one period; expectation for this period pushed at its start.
  task automatic runPeriod(input int nLoads, input logic [17:0] a,
                           input logic [17:0] b, input bit atLast,
                           input string nextTag);
    q.push_back('{cyc / PER, curCode, curTag});
    for (int k = 0; k < PER; k++) begin
      loadStrobe = 1'b0;
      codeIn     = 18'h2AAAA ^ 18'(k * 7);
      if (!atLast && nLoads >= 1 && k == D) begin
        loadStrobe = 1'b1; codeIn = a;
      end
      if (!atLast && nLoads == 2 && k == 2 * D) begin
        loadStrobe = 1'b1; codeIn = b;
      end
      if (atLast && k == PER - 1) begin
        loadStrobe = 1'b1; codeIn = a;
      end
      @(negedge clk);
    end
    loadStrobe = 1'b0;
    if (nLoads == 2) curCode = b;
    else if (nLoads == 1) curCode = a;
    curTag = nextTag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(coarseOut == 16'h0, "R9", "output in reset", coarseOut, 0);
    codeIn = 18'h3FFFF;
    @(negedge clk);
    check(coarseOut == 16'h0, "R9", "reset ignores code input", coarseOut, 0);
    rst = 1'b0;
    runPeriod(1, 18'h12345, 18'h0, 1'b0, "R6 frac 01");
    runPeriod(1, 18'h0ABCE, 18'h0, 1'b0, "R6 frac 10");
    runPeriod(1, 18'h3FFF3, 18'h0, 1'b0, "R6 frac 11");
    runPeriod(1, 18'h00008, 18'h0, 1'b0, "R6 frac 00");
    runPeriod(1, 18'h3FFFF, 18'h0, 1'b0, "R5 full scale");
    runPeriod(1, 18'h3FFFC, 18'h0, 1'b0, "R5 full base frac 00");
    runPeriod(1, 18'h3FFFE, 18'h0, 1'b0, "R5 full base frac 10");
    runPeriod(1, 18'h1FFFF, 18'h0, 1'b1, "R7 load on wrap edge");
    runPeriod(2, 18'h00001, 18'h20003, 1'b0, "R8 last load wins");
    runPeriod(0, 18'h0, 18'h0, 1'b0, "R6 no load held");
    runPeriod(1, 18'h00002, 18'h0, 1'b0, "R6 small code");
    runPeriod(0, 18'h0, 18'h0, 1'b0, "R6 end");
    @(negedge clk);
    check(q.size() == 0, "R3", "all periods observed", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL R3 watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule